// File: doc/BRIEF.md
# Single-Wire Debug Port Initializer

This block is the target end of a half-duplex debug link that runs over one open-drain wire. Characters on the wire are asynchronous frames of eleven bit times. The block learns the host's bit rate from a calibration character and then stays deaf to the host until the host sends the byte that opens a debug session. After that it passes every received byte to a command decoder and flags CRC failures reported by an external CRC checker.

The target never starts a character on its own. When it has a reply byte, it waits until the host pulls the wire low for a start bit, usually by sending an all-ones byte. In the same frame it pulls the wire low for each zero data bit, and it always pulls the parity slot low. The zero in the parity slot is the acknowledge: a silent or absent target would leave the host reading a parity one.

If the session is opened while the device reset pin has been held asserted from before calibration through to the opening byte, a sticky halt flag is raised so that the core stays stopped for debugging. A line held low for longer than a character returns the block to its calibration state.

Top module: `owi_debug_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, all outputs are low, `bit_period_o` is 0, the port is not locked, no session is open and the wire is released.
- R2: The calibration character is 0x7F with a zero parity bit. Its first two falling edges are exactly eight bit periods apart. `bit_period_o` equals that interval in clock cycles divided by eight. `baud_locked_o` rises once the wire returns high after the second falling edge.
- R3: A frame is one low start bit, eight data bits sent least significant bit first, one parity bit and one high stop bit. Each bit is sampled near the middle of its measured bit period.
- R4: When the port is locked but no session is open, any received byte other than 0x00 produces no `rx_valid_o` pulse and leaves the session closed.
- R5: Receiving 0x00 while no session is open sets `session_open_o` and delivers that 0x00 with a one-cycle `rx_valid_o` pulse. Every later byte is delivered the same way, and its value appears on `rx_byte_o`.
- R6: The opening byte carries no CRC. While no session is open, `crc_bad_i` has no effect and `crc_err_o` stays low.
- R7: While a session is open, a one-cycle `crc_bad_i` pulse gives exactly one `crc_err_o` pulse in the following cycle.
- R8: A reply byte is accepted by `tx_load_i` while a session is open. The block does not pull the wire until the host drives a start bit. From the following bit slot on, it pulls low for each zero data bit, least significant bit first. `tx_done_o` pulses and `tx_busy_o` clears when the frame ends.
- R9: In a reply frame the parity slot is always pulled low, which is the acknowledge. The start and stop slots are never pulled by the block.
- R10: `halt_o` is set when the session opens if `dev_reset_i` was asserted before calibration completed and has stayed asserted up to the opening byte. Once set, it stays set until `rst`.
- R11: `halt_o` stays low when the session opens with `dev_reset_i` deasserted.
- R12: A low level lasting more than eleven bit periods is a break. It clears `baud_locked_o` and `session_open_o`, drops any pending reply, and requires a new calibration character.
- R13: `tx_load_i` is ignored while no session is open: `tx_busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the port |
| dev_reset_i | input | 1 | Device reset pin is asserted |
| line_i | input | 1 | Wire level as received (1 = released high) |
| line_drive_low_o | output | 1 | Pull the wire low (open-drain enable) |
| tx_load_i | input | 1 | Load a reply byte |
| tx_byte_i | input | 8 | Reply byte |
| tx_busy_o | output | 1 | Reply byte waiting for or being sent |
| tx_done_o | output | 1 | One-cycle pulse at the end of a reply frame |
| rx_valid_o | output | 1 | One-cycle pulse for each delivered byte |
| rx_byte_o | output | 8 | Delivered byte |
| crc_bad_i | input | 1 | External checker reports a CRC mismatch |
| crc_err_o | output | 1 | One-cycle CRC error flag |
| baud_locked_o | output | 1 | Bit period measured |
| bit_period_o | output | CNT_W | Measured bit period in clock cycles |
| session_open_o | output | 1 | Debug session open |
| halt_o | output | 1 | Debug halt flag |

## Verification
The properties assume that `crc_bad_i` arrives as single-cycle pulses, that the host keeps one bit period of at least eight clock cycles for a whole session, and that the host drives only the start bit of a frame in which the target replies. They also assume `dev_reset_i` changes only between characters. The bench drives every character with a fixed whole number of cycles per bit (16, then 24 after a break), pulses the CRC input for exactly one cycle, and releases the wire after the start bit of the reply frame.

// File: rtl/owi_pkg.sv
package owi_pkg;
  typedef enum logic [1:0] {FR_IDLE, FR_RX, FR_TX, FR_STOP} fr_state_t;
  typedef enum logic [1:0] {BM_ARM, BM_WAIT, BM_COUNT, BM_DONE} bm_state_t;
  localparam logic [7:0] OPEN_CMD = 8'h00;
  localparam int DATA_BITS = 8;
  localparam int BREAK_BITS = 11;
endpackage

// File: rtl/owi_line_sync.sv
module owi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_s,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], line_i};
  end

  assign line_s = sh[STAGES-1];
  assign fall   = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/owi_baud_meter.sv
module owi_baud_meter
  import owi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             line_s,
  input  logic             fall,
  output logic             locked,
  output logic [CNT_W-1:0] period
);
  bm_state_t        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      st     <= BM_ARM;
      cnt    <= '0;
      locked <= 1'b0;
      period <= '0;
    end else begin
      case (st)
        BM_ARM:  if (line_s) st <= BM_WAIT;
        BM_WAIT: if (fall) begin
          cnt <= CNT_W'(1);
          st  <= BM_COUNT;
        end
        BM_COUNT: begin
          if (fall) begin
            // Eight bit periods between the two edges: divide by shifting.
            if (cnt[CNT_W-1:3] == '0) st <= BM_ARM;
            else begin
              period <= {3'b000, cnt[CNT_W-1:3]};
              st     <= BM_DONE;
            end
          end else if (cnt == '1) begin
            st <= BM_ARM;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: if (line_s) locked <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/owi_break_det.sv
module owi_break_det
  import owi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             line_s,
  input  logic [CNT_W-1:0] period,
  output logic             brk
);
  localparam int LW = CNT_W + 4;

  logic [LW-1:0] run;
  logic [LW-1:0] lim;
  logic [LW-1:0] p_ext;

  assign p_ext = {4'b0000, period};
  // BREAK_BITS (11) bit periods = 8P + 2P + P
  assign lim = (p_ext << 3) + (p_ext << 1) + p_ext;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run <= '0;
      brk <= 1'b0;
    end else begin
      brk <= 1'b0;
      if (line_s) run <= '0;
      else if (run == lim) begin
        brk <= 1'b1;
        run <= '0;
      end else begin
        run <= run + LW'(1);
      end
    end
  end
endmodule

// File: rtl/owi_debug_port.sv
module owi_debug_port
  import owi_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dev_reset_i,
  input  logic             line_i,
  output logic             line_drive_low_o,
  input  logic             tx_load_i,
  input  logic [7:0]       tx_byte_i,
  output logic             tx_busy_o,
  output logic             tx_done_o,
  output logic             rx_valid_o,
  output logic [7:0]       rx_byte_o,
  input  logic             crc_bad_i,
  output logic             crc_err_o,
  output logic             baud_locked_o,
  output logic [CNT_W-1:0] bit_period_o,
  output logic             session_open_o,
  output logic             halt_o
);
  localparam int TW = CNT_W + 4;
  localparam logic [3:0] LAST_DATA = 4'(DATA_BITS);
  localparam logic [3:0] PAR_SLOT  = 4'(DATA_BITS + 1);

  logic             line_s, fall, locked, brk;
  logic [CNT_W-1:0] period;
  logic [TW-1:0]    p_ext, t, nxt;
  fr_state_t        st;
  logic [3:0]       idx;
  logic [2:0]       bsel;
  logic [7:0]       rx_sh, txb;
  logic             pend, open_q, rst_seen, drv_next;

  owi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_i(line_i), .line_s(line_s), .fall(fall)
  );

  owi_baud_meter #(.CNT_W(CNT_W)) u_meter (
    .clk(clk), .rst(rst), .clear(brk), .line_s(line_s), .fall(fall),
    .locked(locked), .period(period)
  );

  owi_break_det #(.CNT_W(CNT_W)) u_brk (
    .clk(clk), .rst(rst), .en(locked), .line_s(line_s), .period(period), .brk(brk)
  );

  assign p_ext = {4'b0000, period};
  assign bsel  = idx[2:0] - 3'd1;

  always_comb begin
    drv_next = 1'b0;
    if (st == FR_TX && idx >= 4'd1 && idx <= PAR_SLOT)
      drv_next = (idx == PAR_SLOT) ? 1'b1 : ~txb[bsel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= FR_IDLE; idx <= '0; t <= '0; nxt <= '0;
      rx_sh <= '0; txb <= '0; pend <= 1'b0; open_q <= 1'b0;
      rst_seen <= 1'b0; halt_o <= 1'b0; line_drive_low_o <= 1'b0;
      rx_valid_o <= 1'b0; rx_byte_o <= '0; tx_done_o <= 1'b0; crc_err_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      tx_done_o  <= 1'b0;
      crc_err_o  <= crc_bad_i & open_q;
      // Reset must be held from before calibration ends up to the opening byte.
      if (!dev_reset_i)  rst_seen <= 1'b0;
      else if (!locked)  rst_seen <= 1'b1;
      if (brk) begin
        st <= FR_IDLE; open_q <= 1'b0; pend <= 1'b0; line_drive_low_o <= 1'b0;
      end else begin
        line_drive_low_o <= drv_next;
        if (tx_load_i && open_q && !pend) begin
          pend <= 1'b1;
          txb  <= tx_byte_i;
        end
        case (st)
          FR_IDLE: if (locked && fall) begin
            t   <= TW'(1);
            idx <= '0;
            if (pend && open_q) begin
              st  <= FR_TX;
              nxt <= p_ext;
            end else begin
              st  <= FR_RX;
              nxt <= p_ext >> 1;
            end
          end
          FR_RX: begin
            t <= t + TW'(1);
            if (t == nxt) begin
              nxt <= nxt + p_ext;
              idx <= idx + 4'd1;
              if (idx >= 4'd1 && idx <= LAST_DATA) rx_sh <= {line_s, rx_sh[7:1]};
              if (idx == PAR_SLOT) begin
                st <= FR_STOP;
                if (open_q) begin
                  rx_valid_o <= 1'b1;
                  rx_byte_o  <= rx_sh;
                end else if (rx_sh == OPEN_CMD) begin
                  open_q     <= 1'b1;
                  rx_valid_o <= 1'b1;
                  rx_byte_o  <= rx_sh;
                  if (rst_seen && dev_reset_i) halt_o <= 1'b1;
                end
              end
            end
          end
          FR_TX: begin
            t <= t + TW'(1);
            if (t == nxt) begin
              nxt <= nxt + p_ext;
              idx <= idx + 4'd1;
              if (idx == PAR_SLOT) begin
                st        <= FR_STOP;
                pend      <= 1'b0;
                tx_done_o <= 1'b1;
              end
            end
          end
          default: if (line_s) st <= FR_IDLE;
        endcase
      end
    end
  end

  assign tx_busy_o      = pend;
  assign baud_locked_o  = locked;
  assign bit_period_o   = period;
  assign session_open_o = open_q;
endmodule

// File: rtl/owi_debug_port_chk.sv
module owi_debug_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       dev_reset_i,
  input logic       line_drive_low_o,
  input logic       tx_busy_o,
  input logic       tx_done_o,
  input logic       rx_valid_o,
  input logic [7:0] rx_byte_o,
  input logic       crc_bad_i,
  input logic       crc_err_o,
  input logic       baud_locked_o,
  input logic       session_open_o,
  input logic       halt_o
);
  p_drive_needs_reply_r8: assert property (@(posedge clk) disable iff (rst)
    line_drive_low_o |-> $past(tx_busy_o));

  p_done_clears_busy_r8: assert property (@(posedge clk) disable iff (rst)
    tx_done_o |-> !tx_busy_o);

  p_rx_only_open_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> session_open_o);

  p_open_by_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && $rose(session_open_o)) |-> (rx_byte_o == 8'h00));

  p_crc_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
    crc_err_o |-> ($past(crc_bad_i) && $past(session_open_o)));

  p_crc_closed_r6: assert property (@(posedge clk) disable iff (rst)
    (crc_bad_i && !session_open_o) |=> !crc_err_o);

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> halt_o);

  p_halt_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(halt_o) |-> ($past(dev_reset_i) && $rose(session_open_o)));

  p_open_needs_lock_r12: assert property (@(posedge clk) disable iff (rst)
    session_open_o |-> baud_locked_o);
endmodule

bind owi_debug_port owi_debug_port_chk u_chk (
  .clk(clk), .rst(rst), .dev_reset_i(dev_reset_i),
  .line_drive_low_o(line_drive_low_o), .tx_busy_o(tx_busy_o), .tx_done_o(tx_done_o),
  .rx_valid_o(rx_valid_o), .rx_byte_o(rx_byte_o), .crc_bad_i(crc_bad_i),
  .crc_err_o(crc_err_o), .baud_locked_o(baud_locked_o),
  .session_open_o(session_open_o), .halt_o(halt_o)
);

// File: tb/owi_debug_port_tb.sv
`timescale 1ns/1ps
module owi_debug_port_tb_top;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dev_reset = 1'b0;
  logic host_low = 1'b0;
  logic line_w;
  logic drv_low, tx_load, tx_busy, tx_done, rx_valid, crc_bad, crc_err;
  logic locked, sess, halt;
  logic [7:0] tx_byte, rx_byte;
  logic [CNT_W-1:0] period;

  int n_chk = 0, n_bad = 0;
  int rx_cnt = 0, crc_cnt = 0, done_cnt = 0;
  logic [7:0] rx_last = 8'h00;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign line_w = ~(host_low | drv_low);

  owi_debug_port #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .dev_reset_i(dev_reset), .line_i(line_w),
    .line_drive_low_o(drv_low), .tx_load_i(tx_load), .tx_byte_i(tx_byte),
    .tx_busy_o(tx_busy), .tx_done_o(tx_done), .rx_valid_o(rx_valid),
    .rx_byte_o(rx_byte), .crc_bad_i(crc_bad), .crc_err_o(crc_err),
    .baud_locked_o(locked), .bit_period_o(period), .session_open_o(sess),
    .halt_o(halt)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end
    if (crc_err)  crc_cnt++;
    if (tx_done)  done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic send_char(input logic [7:0] b, input bit par, input int p);
    logic [10:0] fr;
    fr = {1'b1, par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      host_low = ~fr[i];
      repeat (p) @(negedge clk);
    end
    host_low = 1'b0;
    repeat (2 * p) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk(!locked && !sess && !halt && !drv_low && !tx_busy && !rx_valid && !crc_err,
        "R1 status low in reset", {locked, sess, halt, drv_low}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(period == 0 && !locked && !sess, "R1 after reset", int'(period), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_autobaud(input int p);
    send_char(8'h7F, 1'b0, p);
    chk(locked, "R2 locked", locked, 1);
    chk(period == p, "R2 bit period", int'(period), p);
  endtask

  task automatic t_ignore(input int p);
    int c0, e0;
    c0 = rx_cnt;
    send_char(8'h55, 1'b0, p);
    send_char(8'hFF, 1'b1, p);
    chk(rx_cnt == c0, "R4 bytes before open dropped", rx_cnt - c0, 0);
    chk(!sess, "R4 session still closed", sess, 0);
    e0 = crc_cnt;
    crc_bad = 1'b1; @(negedge clk); crc_bad = 1'b0;
    repeat (3) @(negedge clk);
    chk(crc_cnt == e0, "R6 crc ignored before open", crc_cnt - e0, 0);
    tx_byte = 8'h99; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    @(negedge clk);
    chk(!tx_busy, "R13 load ignored before open", tx_busy, 0);
  endtask

  task automatic t_open(input int p, input bit exp_halt);
    int c0;
    c0 = rx_cnt;
    send_char(8'h00, 1'b0, p);
    chk(rx_cnt == c0 + 1 && rx_last == 8'h00, "R5 opening byte delivered", rx_cnt - c0, 1);
    chk(sess, "R5 session open", sess, 1);
    chk(halt == exp_halt, exp_halt ? "R10 halt set" : "R11 halt clear", halt, exp_halt);
  endtask

  task automatic t_rx(input int p, input logic [7:0] b);
    int c0;
    c0 = rx_cnt;
    send_char(b, ^b, p);
    chk(rx_cnt == c0 + 1, "R5 byte delivered", rx_cnt - c0, 1);
    chk(rx_last == b, "R3 byte value", rx_last, b);
  endtask

  task automatic t_crc();
    int e0;
    e0 = crc_cnt;
    crc_bad = 1'b1; @(negedge clk); crc_bad = 1'b0;
    chk(crc_err, "R7 crc error next cycle", crc_err, 1);
    @(negedge clk);
    chk(!crc_err, "R7 crc error one cycle", crc_err, 0);
    repeat (2) @(negedge clk);
    chk(crc_cnt == e0 + 1, "R7 single pulse", crc_cnt - e0, 1);
  endtask

  task automatic t_tx(input int p, input logic [7:0] b);
    bit quiet;
    logic [10:0] got;
    int d0;
    d0 = done_cnt;
    tx_byte = b; tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    chk(tx_busy, "R8 reply accepted", tx_busy, 1);
    quiet = 1'b1;
    for (int i = 0; i < 3 * p; i++) begin
      if (drv_low) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R8 no drive before host start", quiet, 1);
    host_low = 1'b1;
    repeat (p / 2) @(negedge clk);
    got[0] = line_w;
    repeat (p - p / 2) @(negedge clk);
    host_low = 1'b0;
    repeat (p / 2) @(negedge clk);
    got[1] = line_w;
    for (int i = 2; i <= 10; i++) begin
      repeat (p) @(negedge clk);
      got[i] = line_w;
    end
    chk(got[8:1] == b, "R8 reply data", got[8:1], b);
    chk(got[9] == 1'b0, "R9 parity ack low", got[9], 0);
    chk(got[0] == 1'b0 && got[10] == 1'b1, "R9 start and stop", {got[10], got[0]}, 2);
    repeat (p) @(negedge clk);
    chk(done_cnt == d0 + 1 && !tx_busy, "R8 reply done", done_cnt - d0, 1);
  endtask

  task automatic t_break(input int p);
    host_low = 1'b1;
    repeat (12 * p) @(negedge clk);
    host_low = 1'b0;
    repeat (2 * p) @(negedge clk);
    chk(!locked, "R12 lock dropped", locked, 0);
    chk(!sess, "R12 session closed", sess, 0);
  endtask

  initial begin
    tx_load = 1'b0; tx_byte = 8'h00; crc_bad = 1'b0;
    t_reset();
    t_autobaud(16);
    t_ignore(16);
    t_open(16, 1'b0);
    t_rx(16, 8'hA5);
    t_rx(16, 8'h3C);
    t_crc();
    t_tx(16, 8'hA5);
    t_tx(16, 8'h01);
    t_break(16);
    dev_reset = 1'b1;
    repeat (8) @(negedge clk);
    t_autobaud(24);
    t_ignore(24);
    t_open(24, 1'b1);
    dev_reset = 1'b0;
    t_rx(24, 8'hC3);
    chk(halt, "R10 halt sticky", halt, 1);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule